// File: doc/BRIEF.md
# Integer Execute Unit for 32/64-bit Arithmetic Classes

This block is the execute stage for the arithmetic instruction classes of a 64-bit register machine. Each cycle in which `in_valid` is high, it takes the 8-bit operation byte, the 16-bit offset field, the 32-bit immediate and the current values of the destination and source registers. It computes the value to write back to the destination register and registers it, together with a flag that marks a reserved encoding. The unit covers add, subtract, multiply, unsigned and signed divide and remainder, the three bitwise operations, the three shifts, negate, plain and sign-extending move, and byte-order conversion. Each has a narrow (32-bit) and a wide (64-bit) flavour.

The operation byte carries the class in bits [2:0]: 0x4 is narrow and 0x7 is wide. Bit 3 picks the second operand: 0 means the immediate and 1 means the source register. Bits [7:4] hold the operation code. Divide-by-zero and remainder-by-zero produce defined values, so the unit never traps. The surrounding pipeline uses `illegal` to discard a reserved encoding.

The stage holds no state machine. It has a single output register stage that is loaded only on `in_valid`. `out_valid` follows `in_valid` by one cycle, and `result` and `illegal` hold their values between accepted operations.

Top module: `alu_exec_unit`

## Requirements
- R1: For a legal narrow-class (class 0x4) operation other than byte conversion, bits [63:32] of `result` are zero. Bits [31:0] are the 32-bit outcome computed from the low halves of the operands.
- R2: Add (0x0), subtract (0x1), multiply (0x2), or (0x4), and (0x5), xor (0xa) and move (0xb, offset 0) wrap modulo the operand width. In the wide class (0x7), the immediate is sign-extended from 32 to 64 bits before use.
- R3: Divide (0x3) and remainder (0x9) are unsigned when offset is 0 and signed when offset is 1. Signed results truncate toward zero, so -13 rem 3 = -1. The most negative value divided by -1 gives the most negative value, with remainder 0. A wide-class unsigned divide by an immediate uses the sign-extended immediate.
- R4: A divide whose divisor is zero gives 0.
- R5: A remainder whose divisor is zero leaves the destination value unchanged in the wide class. In the narrow class it keeps the low 32 bits and clears the upper 32 bits.
- R6: The left shift (0x6), logical right shift (0x7) and arithmetic right shift (0xc) use the shift count masked to 6 bits (wide) or 5 bits (narrow). The arithmetic shift fills with the sign bit of the 64-bit or 32-bit operand.
- R7: Negate (0x8) gives the two's complement of the destination value, truncated to the width of the class.
- R8: Move with offset 8, 16 or 32 sign-extends that many low bits of the source register. In the narrow class only 8 and 16 are accepted, and the result is then zero-extended above bit 31.
- R9: Byte conversion (0xd) uses an immediate of 16, 32 or 64 as the width. The result is the destination value restricted to that width and zero-extended above it. The bytes within the width are reversed in the wide class (which requires source bit 0), and in the narrow class when source bit 3 is 1 (big-endian). They are kept in order in the narrow class when source bit 3 is 0 (little-endian host). This rule applies in place of R1.
- R10: `illegal` is 1 and `result` is 0 for any of the following encodings: a class other than 0x4 or 0x7; operation code 0xe or 0xf; negate with bit 3 set; divide or remainder with an offset other than 0 or 1; move with an offset other than 0, 8, 16 or 32, or with a sign-extending offset and bit 3 clear, or with offset 32 in the narrow class; byte conversion with an immediate other than 16, 32 or 64, or with bit 3 set in the wide class.
- R11: `out_valid`, `result` and `illegal` reset to 0. `out_valid` equals `in_valid` of the previous cycle. `result` and `illegal` change only one cycle after a cycle with `in_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 8 | Operation byte: code [7:4], source select [3], class [2:0] |
| offset | input | 16 | Offset field (signedness / sign-extend width selector) |
| imm | input | 32 | Immediate field |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Current source register value |
| out_valid | output | 1 | Result registered from previous cycle's operation |
| result | output | 64 | Value to write back to the destination register |
| illegal | output | 1 | Registered reserved-encoding flag |

## Verification
The hardest cases to reach are the divider corners. One is the most negative dividend over -1, where a plain signed division overflows. The other is remainder-by-zero in the narrow class: that case is only visible when the destination's upper half holds nonzero data, which the result must then drop. The vector table seeds the upper halves of both register inputs with unrelated patterns and supplies divisors of zero, -1 and an all-ones immediate, so each of these corners lands on a distinct expected value. A directed sequence then changes every input with `in_valid` low and confirms that the registered outputs do not move.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    localparam logic [2:0] CLS_NARROW = 3'h4;
    localparam logic [2:0] CLS_WIDE   = 3'h7;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_SHL  = 4'h6,
        OP_SHR  = 4'h7,
        OP_NEG  = 4'h8,
        OP_REM  = 4'h9,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_ASR  = 4'hc,
        OP_SWAP = 4'hd,
        OP_RSVE = 4'he,
        OP_RSVF = 4'hf
    } alu_op_t;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int WORD_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              is_narrow,
    input  logic              use_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic [WORD_W-1:0] src_val,
    output logic [WORD_W-1:0] opnd,
    output logic              opnd_zero
);
    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] imm_ext;
    logic [WORD_W-1:0] picked;

    always_comb begin
        imm_ext = {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};
        picked  = use_reg ? src_val : imm_ext;
        if (is_narrow) begin
            opnd = {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
        end else begin
            opnd = picked;
        end
        opnd_zero = (opnd == '0);
    end
endmodule

// File: rtl/alu_divmod.sv
module alu_divmod #(
    parameter int WORD_W = 64
) (
    input  logic              is_narrow,
    input  logic              is_signed,
    input  logic [WORD_W-1:0] num,
    input  logic [WORD_W-1:0] den,
    output logic [WORD_W-1:0] quo,
    output logic [WORD_W-1:0] rem
);
    localparam int HALF_W = WORD_W / 2;

    logic signed [WORD_W-1:0] w_sn, w_sd;
    logic signed [HALF_W-1:0] n_sn, n_sd;
    logic [WORD_W-1:0] w_q, w_r;
    logic [HALF_W-1:0] n_num, n_den, n_q, n_r;

    always_comb begin
        w_sn = num;
        w_sd = den;
        if (den == '0) begin
            w_q = '0;
            w_r = num;
        end else if (is_signed && den == '1) begin
            w_q = '0 - num;
            w_r = '0;
        end else if (is_signed) begin
            w_q = w_sn / w_sd;
            w_r = w_sn % w_sd;
        end else begin
            w_q = num / den;
            w_r = num % den;
        end
    end

    always_comb begin
        n_num = num[HALF_W-1:0];
        n_den = den[HALF_W-1:0];
        n_sn  = n_num;
        n_sd  = n_den;
        if (n_den == '0) begin
            n_q = '0;
            n_r = n_num;
        end else if (is_signed && n_den == '1) begin
            n_q = '0 - n_num;
            n_r = '0;
        end else if (is_signed) begin
            n_q = n_sn / n_sd;
            n_r = n_sn % n_sd;
        end else begin
            n_q = n_num / n_den;
            n_r = n_num % n_den;
        end
    end

    always_comb begin
        if (is_narrow) begin
            quo = {{HALF_W{1'b0}}, n_q};
            rem = {{HALF_W{1'b0}}, n_r};
        end else begin
            quo = w_q;
            rem = w_r;
        end
    end
endmodule

// File: rtl/alu_byteswap.sv
module alu_byteswap #(
    parameter int WORD_W = 64,
    parameter int NB     = WORD_W / 8,
    parameter int CNT_W  = $clog2(NB) + 1
) (
    input  logic [WORD_W-1:0] val,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              reverse,
    output logic [WORD_W-1:0] out
);
    logic [7:0] lane [NB];
    logic [7:0] picked [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane[g] = val[8*g +: 8];
        assign out[8*g +: 8] = picked[g];
    end

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            picked[i] = 8'h00;
            if (i < int'(nbytes)) begin
                if (reverse) begin
                    picked[i] = lane[(int'(nbytes) - 1 - i) % NB];
                end else begin
                    picked[i] = lane[i];
                end
            end
        end
    end
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
    import alu_exec_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int IMM_W  = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IMM_W-1:0]  imm,
    input  logic [WORD_W-1:0] dst_val,
    input  logic [WORD_W-1:0] src_val,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              illegal
);
    localparam int HALF_W = WORD_W / 2;
    localparam int SH_W   = $clog2(WORD_W);
    localparam int SHN_W  = $clog2(HALF_W);
    localparam int NB     = WORD_W / 8;
    localparam int CNT_W  = $clog2(NB) + 1;

    logic [2:0] cls;
    logic       use_reg;
    alu_op_t    op;
    logic       is_narrow, is_wide;

    assign cls       = opcode[2:0];
    assign use_reg   = opcode[3];
    assign op        = alu_op_t'(opcode[7:4]);
    assign is_narrow = (cls == CLS_NARROW);
    assign is_wide   = (cls == CLS_WIDE);

    logic [WORD_W-1:0] opnd;
    logic              opnd_zero;

    alu_operand_sel #(.WORD_W(WORD_W), .IMM_W(IMM_W)) opsel_i (
        .is_narrow (is_narrow),
        .use_reg   (use_reg),
        .imm       (imm),
        .src_val   (src_val),
        .opnd      (opnd),
        .opnd_zero (opnd_zero)
    );

    logic              div_signed;
    logic [WORD_W-1:0] quo, rem;

    assign div_signed = (offset == OFF_W'(1));

    alu_divmod #(.WORD_W(WORD_W)) divmod_i (
        .is_narrow (is_narrow),
        .is_signed (div_signed),
        .num       (dst_val),
        .den       (opnd),
        .quo       (quo),
        .rem       (rem)
    );

    logic [CNT_W-1:0]  swap_nb;
    logic              swap_bad;
    logic [WORD_W-1:0] swap_out;

    always_comb begin
        swap_bad = 1'b0;
        unique case (imm)
            IMM_W'(16): swap_nb = CNT_W'(2);
            IMM_W'(32): swap_nb = CNT_W'(4);
            IMM_W'(64): swap_nb = CNT_W'(8);
            default: begin
                swap_nb  = '0;
                swap_bad = 1'b1;
            end
        endcase
    end

    alu_byteswap #(.WORD_W(WORD_W)) swap_i (
        .val     (dst_val),
        .nbytes  (swap_nb),
        .reverse (is_wide | use_reg),
        .out     (swap_out)
    );

    logic [WORD_W-1:0] sx_val;
    logic              sx_bad;

    always_comb begin
        sx_bad = 1'b0;
        unique case (offset)
            OFF_W'(8):  sx_val = {{(WORD_W-8){src_val[7]}}, src_val[7:0]};
            OFF_W'(16): sx_val = {{(WORD_W-16){src_val[15]}}, src_val[15:0]};
            OFF_W'(32): begin
                sx_val = {{(WORD_W-32){src_val[31]}}, src_val[31:0]};
                sx_bad = is_narrow;
            end
            default: begin
                sx_val = '0;
                sx_bad = (offset != '0);
            end
        endcase
        if (offset != '0 && !use_reg) begin
            sx_bad = 1'b1;
        end
    end

    logic [HALF_W-1:0] n_shl, n_shr, n_asr;
    logic [SHN_W-1:0]  n_amt;
    logic [SH_W-1:0]   w_amt;

    always_comb begin
        n_amt = opnd[SHN_W-1:0];
        w_amt = opnd[SH_W-1:0];
        n_shl = dst_val[HALF_W-1:0] << n_amt;
        n_shr = dst_val[HALF_W-1:0] >> n_amt;
        n_asr = HALF_W'($signed(dst_val[HALF_W-1:0]) >>> n_amt);
    end

    logic [WORD_W-1:0] raw_c, res_c;
    logic              ill_c;

    always_comb begin
        ill_c = 1'b0;
        if (!is_narrow && !is_wide) begin
            ill_c = 1'b1;
        end
        unique case (op)
            OP_ADD:  raw_c = dst_val + opnd;
            OP_SUB:  raw_c = dst_val - opnd;
            OP_MUL:  raw_c = dst_val * opnd;
            OP_DIV: begin
                raw_c = quo;
                if (offset > OFF_W'(1)) ill_c = 1'b1;
            end
            OP_OR:   raw_c = dst_val | opnd;
            OP_AND:  raw_c = dst_val & opnd;
            OP_SHL:  raw_c = is_narrow ? {{HALF_W{1'b0}}, n_shl} : dst_val << w_amt;
            OP_SHR:  raw_c = is_narrow ? {{HALF_W{1'b0}}, n_shr} : dst_val >> w_amt;
            OP_NEG: begin
                raw_c = '0 - dst_val;
                if (use_reg) ill_c = 1'b1;
            end
            OP_REM: begin
                raw_c = rem;
                if (offset > OFF_W'(1)) ill_c = 1'b1;
            end
            OP_XOR:  raw_c = dst_val ^ opnd;
            OP_MOV: begin
                raw_c = (offset == '0) ? opnd : sx_val;
                if (sx_bad) ill_c = 1'b1;
            end
            OP_ASR:  raw_c = is_narrow ? {{HALF_W{1'b0}}, n_asr}
                                       : WORD_W'($signed(dst_val) >>> w_amt);
            OP_SWAP: begin
                raw_c = swap_out;
                if (swap_bad || (is_wide && use_reg)) ill_c = 1'b1;
            end
            default: begin
                raw_c = '0;
                ill_c = 1'b1;
            end
        endcase
        if (ill_c) begin
            res_c = '0;
        end else if (is_narrow && op != OP_SWAP) begin
            res_c = {{HALF_W{1'b0}}, raw_c[HALF_W-1:0]};
        end else begin
            res_c = raw_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= res_c;
                illegal <= ill_c;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(illegal))); // R11
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0)); // R10
    AST_NEG_REG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (is_narrow || is_wide) && op == OP_NEG && use_reg) |=> illegal); // R10
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_narrow && op != OP_SWAP) |=> (result[WORD_W-1:HALF_W] == '0)); // R1
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ill_c && op == OP_DIV && opnd_zero) |=> (result == '0)); // R4
    AST_WIDE_REM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ill_c && is_wide && op == OP_REM && opnd_zero) |=> (result == $past(dst_val))); // R5

endmodule

// File: tb/alu_exec_unit_tb.sv
`timescale 1ns/1ps
module alu_exec_unit_tb_top;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] off;
        logic [31:0] imm;
        logic [63:0] dv;
        logic [63:0] sv;
        logic [63:0] exp;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 50;
    localparam vec_t VECS [NV] = '{
        // R2 wrap, wide register add
        '{8'h0f, 16'd0, 32'd0, 64'hFFFFFFFFFFFFFFFF, 64'd2, 64'd1, 1'b0, 8'd2},
        // R1 narrow add drops upper half
        '{8'h04, 16'd0, 32'd2, 64'h12345678FFFFFFFF, 64'd0, 64'd1, 1'b0, 8'd1},
        '{8'h17, 16'd0, 32'd1, 64'd0, 64'd0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 8'd2},
        // R2 sign-extended immediate
        '{8'h07, 16'd0, 32'hFFFFFFFF, 64'd5, 64'd0, 64'd4, 1'b0, 8'd2},
        '{8'h2c, 16'd0, 32'd0, 64'h0000000300010001, 64'h0000000000010001, 64'h0000000000020001, 1'b0, 8'd1},
        '{8'h2f, 16'd0, 32'd0, 64'h0000000100000000, 64'h0000000100000003, 64'h0000000300000000, 1'b0, 8'd2},
        // R3 unsigned / signed divide and remainder
        '{8'h3f, 16'd0, 32'd0, 64'd100, 64'd7, 64'd14, 1'b0, 8'd3},
        // R4 divide by zero
        '{8'h3f, 16'd0, 32'd0, 64'd100, 64'd0, 64'd0, 1'b0, 8'd4},
        '{8'h3f, 16'd1, 32'd0, 64'hFFFFFFFFFFFFFFF3, 64'd3, 64'hFFFFFFFFFFFFFFFC, 1'b0, 8'd3},
        '{8'h9f, 16'd1, 32'd0, 64'hFFFFFFFFFFFFFFF3, 64'd3, 64'hFFFFFFFFFFFFFFFF, 1'b0, 8'd3},
        // R5 remainder by zero, wide keeps, narrow zero-extends
        '{8'h9f, 16'd0, 32'd0, 64'hDEADBEEF00000007, 64'd0, 64'hDEADBEEF00000007, 1'b0, 8'd5},
        '{8'h9c, 16'd0, 32'd0, 64'hDEADBEEF00000007, 64'hABCD000000000000, 64'h0000000000000007, 1'b0, 8'd5},
        '{8'h37, 16'd0, 32'hFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'd0, 64'd1, 1'b0, 8'd3},
        '{8'h34, 16'd0, 32'hFFFFFFFF, 64'h00000001FFFFFFFF, 64'd0, 64'd1, 1'b0, 8'd3},
        '{8'h3c, 16'd1, 32'd0, 64'hAAAAAAAAFFFFFFF3, 64'h5555555500000003, 64'h00000000FFFFFFFC, 1'b0, 8'd3},
        '{8'h9c, 16'd1, 32'd0, 64'hAAAAAAAAFFFFFFF3, 64'h00000000FFFFFFFD, 64'h00000000FFFFFFFF, 1'b0, 8'd3},
        '{8'h3f, 16'd1, 32'd0, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000, 1'b0, 8'd3},
        '{8'h9f, 16'd1, 32'd0, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'd0, 1'b0, 8'd3},
        '{8'h47, 16'd0, 32'h80000000, 64'd1, 64'd0, 64'hFFFFFFFF80000001, 1'b0, 8'd2},
        '{8'h5c, 16'd0, 32'd0, 64'hFFFFFFFFF0F0F0F0, 64'h12345678FF00FF00, 64'h00000000F000F000, 1'b0, 8'd1},
        '{8'haf, 16'd0, 32'd0, 64'h000000000000FF00, 64'h0000000000000FF0, 64'h000000000000F0F0, 1'b0, 8'd2},
        // R6 shifts with masked counts
        '{8'h6f, 16'd0, 32'd0, 64'd1, 64'h41, 64'd2, 1'b0, 8'd6},
        '{8'h64, 16'd0, 32'd33, 64'h0000000080000001, 64'd0, 64'd2, 1'b0, 8'd6},
        '{8'h7c, 16'd0, 32'd0, 64'hFFFFFFFF80000000, 64'd31, 64'd1, 1'b0, 8'd6},
        '{8'h77, 16'd0, 32'd4, 64'hF000000000000000, 64'd0, 64'h0F00000000000000, 1'b0, 8'd6},
        '{8'hc7, 16'd0, 32'd4, 64'hF000000000000000, 64'd0, 64'hFF00000000000000, 1'b0, 8'd6},
        '{8'hc4, 16'd0, 32'd4, 64'h0000000080000000, 64'd0, 64'h00000000F8000000, 1'b0, 8'd6},
        // R7 negate
        '{8'h87, 16'd0, 32'd0, 64'd1, 64'd0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 8'd7},
        '{8'h84, 16'd0, 32'd0, 64'd1, 64'd0, 64'h00000000FFFFFFFF, 1'b0, 8'd7},
        // R10 negate with register source
        '{8'h8f, 16'd0, 32'd0, 64'd1, 64'd0, 64'd0, 1'b1, 8'd10},
        '{8'hb7, 16'd0, 32'hFFFFFFFE, 64'd0, 64'd0, 64'hFFFFFFFFFFFFFFFE, 1'b0, 8'd2},
        '{8'hb4, 16'd0, 32'hFFFFFFFE, 64'd0, 64'd0, 64'h00000000FFFFFFFE, 1'b0, 8'd1},
        // R8 sign-extending moves
        '{8'hbf, 16'd8, 32'd0, 64'd0, 64'h0000000000000080, 64'hFFFFFFFFFFFFFF80, 1'b0, 8'd8},
        '{8'hbf, 16'd16, 32'd0, 64'd0, 64'h1234000000007FFF, 64'h0000000000007FFF, 1'b0, 8'd8},
        '{8'hbf, 16'd32, 32'd0, 64'd0, 64'h0000000080000000, 64'hFFFFFFFF80000000, 1'b0, 8'd8},
        '{8'hbc, 16'd16, 32'd0, 64'd0, 64'h0000000000008000, 64'h00000000FFFF8000, 1'b0, 8'd8},
        '{8'hbc, 16'd32, 32'd0, 64'd0, 64'h0000000080000000, 64'd0, 1'b1, 8'd10},
        '{8'hb7, 16'd8, 32'd0, 64'd0, 64'h80, 64'd0, 1'b1, 8'd10},
        // R9 byte conversion
        '{8'hd4, 16'd0, 32'd16, 64'h1122334455667788, 64'd0, 64'h0000000000007788, 1'b0, 8'd9},
        '{8'hdc, 16'd0, 32'd16, 64'h1122334455667788, 64'd0, 64'h0000000000008877, 1'b0, 8'd9},
        '{8'hdc, 16'd0, 32'd32, 64'h1122334455667788, 64'd0, 64'h0000000088776655, 1'b0, 8'd9},
        '{8'hdc, 16'd0, 32'd64, 64'h1122334455667788, 64'd0, 64'h8877665544332211, 1'b0, 8'd9},
        '{8'hd4, 16'd0, 32'd64, 64'h1122334455667788, 64'd0, 64'h1122334455667788, 1'b0, 8'd9},
        '{8'hd7, 16'd0, 32'd32, 64'h1122334455667788, 64'd0, 64'h0000000088776655, 1'b0, 8'd9},
        '{8'hd7, 16'd0, 32'd64, 64'h1122334455667788, 64'd0, 64'h8877665544332211, 1'b0, 8'd9},
        // R10 reserved encodings
        '{8'hdf, 16'd0, 32'd64, 64'h1122334455667788, 64'd0, 64'd0, 1'b1, 8'd10},
        '{8'hd7, 16'd0, 32'd8, 64'h1122334455667788, 64'd0, 64'd0, 1'b1, 8'd10},
        '{8'he7, 16'd0, 32'd0, 64'd5, 64'd5, 64'd0, 1'b1, 8'd10},
        '{8'h05, 16'd0, 32'd0, 64'd5, 64'd5, 64'd0, 1'b1, 8'd10},
        '{8'h3f, 16'd2, 32'd0, 64'd100, 64'd7, 64'd0, 1'b1, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    alu_exec_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .offset    (offset),
        .imm       (imm),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .out_valid (out_valid),
        .result    (result),
        .illegal   (illegal)
    );

    task automatic check(input bit ok, input int req, input logic [63:0] act,
                         input logic [63:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R11 watchdog expired: actual %h expected %h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(out_valid == 1'b0, 11, 64'(out_valid), 64'd0, "reset out_valid");
        check(result == '0, 11, result, 64'd0, "reset result");
        check(illegal == 1'b0, 11, 64'(illegal), 64'd0, "reset illegal");
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            opcode   = VECS[k].op;
            offset   = VECS[k].off;
            imm      = VECS[k].imm;
            dst_val  = VECS[k].dv;
            src_val  = VECS[k].sv;
            in_valid = 1'b1;
            @(negedge clk);
            check(result == VECS[k].exp, int'(VECS[k].req), result, VECS[k].exp,
                  $sformatf("vector %0d result", k));
            check(illegal == VECS[k].ill, int'(VECS[k].req), 64'(illegal), 64'(VECS[k].ill),
                  $sformatf("vector %0d illegal", k));
            check(out_valid == 1'b1, 11, 64'(out_valid), 64'd1, "out_valid after accepted op");
        end

        // R11 hold: inputs change with in_valid low, outputs must not move
        opcode   = 8'h0f; offset = 16'd0; imm = 32'd0;
        dst_val  = 64'd40; src_val = 64'd2;
        @(negedge clk);
        held = result;
        check(result == 64'd42, 2, result, 64'd42, "hold setup add");
        in_valid = 1'b0;
        opcode   = 8'h8f;
        dst_val  = 64'h123456789ABCDEF0;
        src_val  = 64'hFFFFFFFFFFFFFFFF;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, 11, 64'(out_valid), 64'd0, "out_valid idle");
        check(result == held, 11, result, held, "result held while idle");
        check(illegal == 1'b0, 11, 64'(illegal), 64'd0, "illegal held while idle");

        // R5 narrow remainder by immediate zero with junk upper destination
        in_valid = 1'b1;
        opcode   = 8'h94; offset = 16'd1; imm = 32'd0;
        dst_val  = 64'hFFFFFFFF87654321;
        @(negedge clk);
        check(result == 64'h0000000087654321, 5, result, 64'h0000000087654321, "signed narrow rem by zero");

        // R4 narrow signed divide by zero
        opcode = 8'h34;
        @(negedge clk);
        check(result == 64'd0, 4, result, 64'd0, "narrow signed div by zero");

        // R11 reset clears again
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(result == '0 && out_valid == 1'b0, 11, result, 64'd0, "second reset");
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule